// File: doc/BRIEF.md
# Multi-Domain Clock Rate Meter

This block estimates the frequencies of six clocks, each of them asynchronous to the others, by counting their rising edges over a known interval. Each clock has its own free-running counter. Index 0 counts the system clock and index 1 counts the shared transmit MAC clock. Indices 2 to 5 count the receive clocks of MACs 0 to 3. A single control word, written from the register clock domain, holds a run enable and a clear bit for each counter and a read-select field. A read-only count port returns the value of the selected counter.

Software uses the block in a fixed order. It stops and clears the counters, releases the clear, runs them for a known time, stops them again and then reads each one. For example, over 1 ms a 62.5 MHz clock gives about 62,500 counts and a 125 MHz clock about 125,000. The run and clear bits reach each counting domain through two-flop synchronizers. The value presented for reading is a copy held in the register domain. It is refreshed only while its counter is stopped and not clearing, so a counter that is still running reads back its last settled value.

Top module: `clk_rate_meter`

## Requirements
- R1: After reset the control word reads 0x0000_3F00, which means every counter is cleared and stopped and select is 0. The count port then reads 0.
- R2: A write stores only the run field (bits 5:0), the clear field (bits 13:8) and the select field (bits 18:16). All other control bits read 0, and the control word does not change without a write.
- R3: When clear bit 8+i is 1, counter i is forced to zero, whatever the state of run bit i.
- R4: When run bit i is 1 and clear bit 8+i is 0, counter i counts the rising edges of its clock. When run bit i is 0, the counter holds its value.
- R5: Counters are CNT_W bits wide (24 by default) and wrap modulo 2^CNT_W.
- R6: A select value of 0 to 5 returns counter i's settled copy. The index mapping is 0 for the system clock, 1 for the transmit clock and 2 to 5 for the receive clocks of MACs 0 to 3.
- R7: A select value of 6 or 7 reads as 0.
- R8: The copy of counter i stays frozen while its run or clear bit is 1. After a stop, repeated reads return the same final count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_clk | input | 6 | Measured clocks, with bit i feeding counter i |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word readback |
| cnt_rdata | output | CNT_W | Settled value of the selected counter |

## Verification
The assertions check, on every register clock, the following behaviour:
- the reset value of the control word;
- field masking on writes, and the control word holding between writes;
- zero readout for select values 6 and 7;
- each counter's copy staying frozen while its run or clear bit is set.

The counting itself depends on the ratio between two unrelated clocks, so only the bench scenarios can show it. They run windows of known length and compare edge counts, within a small tolerance, against each clock's period. They also cover clear priority over run, wrap-around and holding while stopped.

// File: rtl/clkm_pkg.sv
// Shared constants for the clock rate meter: the counter count and the
// control word field layout. The field positions are fixed because
// software depends on them.
package clkm_pkg;
    localparam int NCNT    = 6;
    localparam int RUN_LSB = 0;
    localparam int CLR_LSB = 8;
    localparam int SEL_LSB = 16;
    localparam int SEL_W   = 3;
    localparam logic [31:0] CTL_MASK = 32'h0007_3F3F;
    localparam logic [31:0] CTL_RST  = 32'h0000_3F00;
endpackage

// File: rtl/clkm_sync.sv
// Two-flop synchronizer for W independent single-bit signals.
// Assumes that each bit is a quasi-static level and that the bits are not
// required to arrive together.
module clkm_sync #(
    parameter int         W   = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Resample the asynchronous levels twice in the destination clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST;
            q    <= RST;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/clkm_ctl_reg.sv
// Control word in the register domain. A write keeps only the defined
// fields. Assumes a single-cycle write strobe from the bus decoder.
module clkm_ctl_reg
    import clkm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic [NCNT-1:0]  run,
    output logic [NCNT-1:0]  clr,
    output logic [SEL_W-1:0] sel
);
    logic [31:0] ctl_q;

    // Hold the control word and load the masked write data.
    always_ff @(posedge clk) begin
        if (!rst_n)  ctl_q <= CTL_RST;
        else if (we) ctl_q <= wdata & CTL_MASK;
    end

    assign rdata = ctl_q;
    assign run   = ctl_q[RUN_LSB +: NCNT];
    assign clr   = ctl_q[CLR_LSB +: NCNT];
    assign sel   = ctl_q[SEL_LSB +: SEL_W];
endmodule

// File: rtl/clkm_cnt_domain.sv
// One edge counter in its own clock domain. The run and clear levels are
// synchronized into the domain, and clear wins over run. The module returns
// a busy level, meaning the counter may be changing, for the register side.
// Assumes that meas_clk keeps toggling while rst_n is low.
module clkm_cnt_domain #(
    parameter int CNT_W = 24
) (
    input  logic             meas_clk,
    input  logic             rst_n,
    input  logic             run_a,
    input  logic             clr_a,
    output logic [CNT_W-1:0] cnt,
    output logic             busy
);
    logic [1:0] rst_pipe;
    logic       lrst_n;
    logic [1:0] ctl_s;   // [1] clear, [0] run

    // Bring the reset into this clock domain.
    always_ff @(posedge meas_clk) rst_pipe <= {rst_pipe[0], rst_n};
    assign lrst_n = rst_pipe[1];

    clkm_sync #(.W(2), .RST(2'b10)) u_ctl_sync (
        .clk(meas_clk), .rst_n(lrst_n), .d({clr_a, run_a}), .q(ctl_s)
    );

    // Count edges; clear takes priority over run; wraps naturally.
    always_ff @(posedge meas_clk) begin
        if (!lrst_n)       cnt <= '0;
        else if (ctl_s[1]) cnt <= '0;
        else if (ctl_s[0]) cnt <= cnt + 1'b1;
    end

    // Report whether the counter may move on the next edge.
    always_ff @(posedge meas_clk) begin
        if (!lrst_n) busy <= 1'b1;
        else         busy <= |ctl_s;
    end
endmodule

// File: rtl/clkm_snap.sv
// Register-domain copy of one counter. It captures the counter only when
// the control bits for that counter have been low for HOLD_CYC cycles and
// the echoed busy level is low, so the sampled bus is static. Assumes the
// measured clock is fast enough to answer within HOLD_CYC register cycles.
module clkm_snap #(
    parameter int CNT_W    = 24,
    parameter int HOLD_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             busy_a,
    input  logic [CNT_W-1:0] cnt_a,
    output logic [CNT_W-1:0] snap
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LD = HOLD_W'(HOLD_CYC);

    logic              busy_s;
    logic [HOLD_W-1:0] hold;
    logic              cap_en;

    clkm_sync #(.W(1), .RST(1'b1)) u_busy_sync (
        .clk(clk), .rst_n(rst_n), .d(busy_a), .q(busy_s)
    );

    // Restart the settle timer whenever run or clear is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold <= HOLD_LD;
        else if (run || clr)     hold <= HOLD_LD;
        else if (hold != '0)     hold <= hold - 1'b1;
    end

    assign cap_en = !run && !clr && (hold == '0) && !busy_s;

    // Take a new copy only while the counter is known to be still.
    always_ff @(posedge clk) begin
        if (!rst_n)      snap <= '0;
        else if (cap_en) snap <= cnt_a;
    end
endmodule

// File: rtl/clk_rate_meter.sv
// Top of the clock rate meter. It holds the control word, one counting
// domain and one register-side copy per measured clock, and the read mux.
// Assumes the bus decoder drives ctl_we for one clk cycle per write.
module clk_rate_meter
    import clkm_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int HOLD_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCNT-1:0]  meas_clk,
    input  logic             ctl_we,
    input  logic [31:0]      ctl_wdata,
    output logic [31:0]      ctl_rdata,
    output logic [CNT_W-1:0] cnt_rdata
);
    logic [NCNT-1:0]       run, clr, busy;
    logic [SEL_W-1:0]      sel;
    logic [CNT_W-1:0]      cnt  [NCNT];
    logic [CNT_W-1:0]      snap [NCNT];
    logic [NCNT*CNT_W-1:0] snap_flat;

    clkm_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
        .rdata(ctl_rdata), .run(run), .clr(clr), .sel(sel)
    );

    for (genvar i = 0; i < NCNT; i++) begin : g_ch
        clkm_cnt_domain #(.CNT_W(CNT_W)) u_cnt (
            .meas_clk(meas_clk[i]), .rst_n(rst_n), .run_a(run[i]),
            .clr_a(clr[i]), .cnt(cnt[i]), .busy(busy[i])
        );
        clkm_snap #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_snap (
            .clk(clk), .rst_n(rst_n), .run(run[i]), .clr(clr[i]),
            .busy_a(busy[i]), .cnt_a(cnt[i]), .snap(snap[i])
        );
        assign snap_flat[i*CNT_W +: CNT_W] = snap[i];
    end

    // Present the selected copy; out-of-range selects read zero.
    always_comb begin
        cnt_rdata = '0;
        for (int i = 0; i < NCNT; i++) begin
            if (sel == SEL_W'(i)) cnt_rdata = snap[i];
        end
    end
endmodule

// File: rtl/clkm_checker.sv
// Register-domain properties of the clock rate meter, attached to the top
// module with a bind statement.
module clkm_checker
    import clkm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ctl_we,
    input logic [31:0]           ctl_wdata,
    input logic [31:0]           ctl_rdata,
    input logic [CNT_W-1:0]      cnt_rdata,
    input logic [NCNT*CNT_W-1:0] snap_flat
);
    p_reset_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ctl_rdata == CTL_RST);

    p_write_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> ctl_rdata == ($past(ctl_wdata) & CTL_MASK));

    p_word_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(ctl_rdata));

    p_sel_oob_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[SEL_LSB +: SEL_W] >= 3'd6 |-> cnt_rdata == '0);

    for (genvar i = 0; i < NCNT; i++) begin : g_frz
        p_copy_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_rdata[RUN_LSB + i] || ctl_rdata[CLR_LSB + i])
            |=> $stable(snap_flat[i*CNT_W +: CNT_W]));
    end
endmodule

bind clk_rate_meter clkm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cnt_rdata(cnt_rdata), .snap_flat(snap_flat)
);

// File: tb/sim_clk_rate_meter.sv
`timescale 1ns/1ps
module sim_clk_rate_meter;
    localparam int W    = 12;
    localparam int MODV = 1 << W;
    localparam int TOL  = 6;
    localparam logic [31:0] MASK = 32'h0007_3F3F;
    localparam logic [31:0] RSTV = 32'h0000_3F00;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [5:0]    mclk = '0;
    logic          ctl_we = 0;
    logic [31:0]   ctl_wdata = '0;
    logic [31:0]   ctl_rdata;
    logic [W-1:0]  cnt_rdata;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] model;
    real per [6] = '{16.0, 8.0, 8.0, 10.0, 6.0, 20.0};

    clk_rate_meter #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .meas_clk(mclk), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .cnt_rdata(cnt_rdata)
    );

    always #4 clk = ~clk;                        // 125 MHz register clock
    always #8  mclk[0] = ~mclk[0];
    always #4  mclk[1] = ~mclk[1];
    always #4  mclk[2] = ~mclk[2];
    always #5  mclk[3] = ~mclk[3];
    always #3  mclk[4] = ~mclk[4];
    always #10 mclk[5] = ~mclk[5];

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit near(int act, int exp);
        int d = (act - exp) % MODV;
        if (d < 0) d += MODV;
        return (d <= TOL) || (d >= MODV - TOL);
    endfunction

    function automatic int edges(int cyc, int i);
        return int'(cyc * 8.0 / per[i]) % MODV;
    endfunction

    // Behavioural reference of the control word (R1, R2).
    always @(posedge clk) begin
        if (!rst_n)      model <= RSTV;
        else if (ctl_we) model <= ctl_wdata & MASK;
    end

    // Compare against the reference on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(ctl_rdata == model, "R2", ctl_rdata, model);
            if (model[18:16] >= 3'd6) chk(cnt_rdata == '0, "R7", cnt_rdata, 0);
        end
    end

    task automatic wr(logic [31:0] d);
        @(negedge clk); ctl_we = 1; ctl_wdata = d;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic rd(logic [31:0] base, int sel, output int v);
        wr(base | (32'(sel) << 16));
        v = int'(cnt_rdata);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        int v, v2;
        int first [6];
        repeat (6) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ctl_rdata == RSTV, "R1", ctl_rdata, RSTV);
        chk(cnt_rdata == '0, "R1", cnt_rdata, 0);

        wr(32'h0);                 // release clear, stay stopped
        idle(40);
        for (int i = 0; i < 6; i++) begin
            rd(32'h0, i, v);
            chk(v == 0, "R3", v, 0);
        end

        wr(32'h3F);                // run all for 2000 cycles
        idle(1000);
        rd(32'h3F, 0, v);          // running: copy stays frozen
        chk(v == 0, "R8", v, 0);
        idle(998);
        wr(32'h0);
        idle(40);
        for (int i = 0; i < 6; i++) begin
            rd(32'h0, i, first[i]);
            chk(near(first[i], edges(2000, i)), "R6", first[i], edges(2000, i));
        end
        rd(32'h0, 6, v); chk(v == 0, "R7", v, 0);
        rd(32'h0, 7, v); chk(v == 0, "R7", v, 0);

        wr(32'h3F | 32'h200);      // counter 1 cleared while run is 1
        idle(498);
        wr(32'h0);
        idle(40);
        rd(32'h0, 1, v);
        chk(v == 0, "R3", v, 0);
        rd(32'h0, 0, v);
        chk(near(v, (first[0] + edges(500, 0)) % MODV), "R4", v,
            (first[0] + edges(500, 0)) % MODV);
        idle(30);
        rd(32'h0, 0, v2);
        chk(v2 == v, "R8", v2, v);

        wr(32'h3F00);              // clear all
        idle(30);
        wr(32'h10);                // run counter 4 only, past the wrap point
        idle(3998);
        wr(32'h0);
        idle(40);
        rd(32'h0, 4, v);
        chk(near(v, edges(4000, 4)), "R5", v, edges(4000, 4));
        rd(32'h0, 0, v);
        chk(v == 0, "R4", v, 0);

        wr(32'hFFFF_FFFF);
        chk(ctl_rdata == MASK, "R2", ctl_rdata, MASK);
        idle(5);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule